// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block holds the control bits that steer an on-chip flash array into programming or erasing. The bits are a program-setup bit, a program bit, an erase-setup bit, an erase bit, a software write-enable bit, an emulation-select bit and a three-bit emulation block field. Software reaches them through a byte-wide register port. The block then qualifies them with an external write-enable pin, a watchdog reset, an asynchronous reset and a standby indication.

Its outputs are the effective program-mode and erase-mode strobes sent to the array. It also drives an interrupt/NMI mask and a bus-release-request mask for the rest of the chip, and a warning that the watchdog is not running while a flash operation is armed. Several conditions clear the program and erase bits without any software action. While these conditions hold, software writes to those two bits are dropped. The emulation-select bit keeps the array out of program and erase mode whatever the other bits hold.

Top module: `flash_pe_interlock`

## Requirements
- R1: One clock after the program bit or the erase bit reads as 1, `irqMask` is 1. When neither is set and boot masking is inactive, `irqMask` is 0.
- R2: One clock after the program bit or the erase bit reads as 1, `busRelMask` is 1. Otherwise it is 0, and the boot inputs never affect it.
- R3: When `bootMode` and `bootActive` are both 1, `irqMask` is 1 one clock later. `bootActive` alone with `bootMode` at 0 has no effect.
- R4: Asserting `rstN` low clears every control bit at once, along with all outputs and `busRdata`. A clock edge with `wdtRst` high clears the program and erase bits and leaves the other bits unchanged.
- R5: A clock edge with `standbyIn` high clears the program and erase bits and leaves the other bits unchanged.
- R6: At every clock edge where `fwePin` is 0, the program and erase bits are cleared, or stay cleared.
- R7: At every clock edge where `fwePin` is 1 and the stored software write-enable bit is 0, the program and erase bits are cleared, or stay cleared.
- R8: While the emulation-select bit is 1, `pgmMode` and `eraseMode` are 0 whatever the block field holds.
- R9: `pgmMode` is registered. One clock after the state, it equals program bit AND `fwePin` AND software write-enable bit AND NOT emulation-select. `eraseMode` follows the same rule using the erase bit.
- R10: One clock after the state, `wdtWarn` is 1 exactly when any of program-setup, program, erase-setup or erase is 1 and `wdtEnabled` is 0.
- R11: A write with `busWe` high takes effect at the next clock edge. At address 0 the bits are: bit0 program-setup, bit1 program, bit2 erase-setup, bit3 erase, bit4 software write-enable. At address 1, bits 2:0 are the block field and bit3 is emulation-select. A read with `busRe` high loads `busRdata` at the next edge with that layout, and unused bits read 0. Addresses 2 and 3 read 0. `busRdata` holds its value when `busRe` is low.
- R12: In a cycle where a clearing condition is active (`wdtRst`, `standbyIn`, `fwePin` low, or the stored software write-enable bit at 0), a write of 1 to the program or erase bit is dropped at that same edge. The other bits of the same write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wdtRst | input | 1 | Watchdog reset request, synchronous |
| standbyIn | input | 1 | Standby entry indication |
| fwePin | input | 1 | External flash write-enable pin level |
| bootMode | input | 1 | Chip is in boot mode |
| bootActive | input | 1 | Boot program is running |
| wdtEnabled | input | 1 | Watchdog is running |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| pgmMode | output | 1 | Effective program-mode strobe |
| eraseMode | output | 1 | Effective erase-mode strobe |
| irqMask | output | 1 | Mask for NMI and all interrupts |
| busRelMask | output | 1 | Mask for bus-release requests |
| wdtWarn | output | 1 | Operation armed while watchdog is off |

## Verification
The main sweep tries every 5-bit control-byte value against both pin levels, both watchdog-enable levels and four emulation-byte values. This separates the pin condition, the software-enable condition and the emulation protection, and each of them alone is shown to suppress the mode strobes. Directed sequences write the program bit in the same cycle a clearing condition appears and read it back on the next cycle. This separates a write that is dropped from a bit that is set and then cleared. Standby, watchdog reset and asynchronous reset are each applied with all bits set, which shows that only the program and erase bits are lost. Boot inputs are toggled on their own to show that they reach the interrupt mask but not the bus-release mask.

// File: rtl/flash_ilk_pkg.sv
package flash_ilk_pkg;
  localparam int BLK_W = 3;
  // control byte bit positions (address 0)
  localparam int POS_PSET = 0;
  localparam int POS_PRG  = 1;
  localparam int POS_ESET = 2;
  localparam int POS_ERS  = 3;
  localparam int POS_SWEN = 4;
  // emulation byte: block field in [BLK_W-1:0], select bit above it
  localparam int POS_EMU  = BLK_W;
  localparam int CTL_ADDR = 0;
  localparam int EMU_ADDR = 1;

  typedef struct packed {
    logic wrCtl;
    logic wrEmu;
    logic rdEn;
    logic rdCtl;
    logic rdEmu;
    logic clrPe;
  } strobeT;

  typedef struct packed {
    logic             progSetup;
    logic             prog;
    logic             eraseSetup;
    logic             erase;
    logic             swWe;
    logic             emuSel;
    logic [BLK_W-1:0] emuBlk;
  } flashStateT;
endpackage

// File: rtl/flash_ilk_datapath.sv
module flash_ilk_datapath
  import flash_ilk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] wData,
  output flashStateT        st,
  output logic [DATA_W-1:0] rData
);
  logic [DATA_W-1:0] ctlByte;
  logic [DATA_W-1:0] emuByte;

  always_comb begin
    ctlByte = '0;
    ctlByte[POS_PSET] = st.progSetup;
    ctlByte[POS_PRG]  = st.prog;
    ctlByte[POS_ESET] = st.eraseSetup;
    ctlByte[POS_ERS]  = st.erase;
    ctlByte[POS_SWEN] = st.swWe;
    emuByte = '0;
    emuByte[BLK_W-1:0] = st.emuBlk;
    emuByte[POS_EMU]   = st.emuSel;
  end

  // program and erase bits: a clearing condition wins over any write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st.prog  <= 1'b0;
      st.erase <= 1'b0;
    end else if (strb.clrPe) begin
      st.prog  <= 1'b0;
      st.erase <= 1'b0;
    end else if (strb.wrCtl) begin
      st.prog  <= wData[POS_PRG];
      st.erase <= wData[POS_ERS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st.progSetup  <= 1'b0;
      st.eraseSetup <= 1'b0;
      st.swWe       <= 1'b0;
    end else if (strb.wrCtl) begin
      st.progSetup  <= wData[POS_PSET];
      st.eraseSetup <= wData[POS_ESET];
      st.swWe       <= wData[POS_SWEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st.emuSel <= 1'b0;
      st.emuBlk <= '0;
    end else if (strb.wrEmu) begin
      st.emuSel <= wData[POS_EMU];
      st.emuBlk <= wData[BLK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rData <= '0;
    else if (strb.rdEn) begin
      if (strb.rdCtl)      rData <= ctlByte;
      else if (strb.rdEmu) rData <= emuByte;
      else                 rData <= '0;
    end
  end

  // R12: a write dropped in a clearing cycle leaves the bit unchanged
  assert_drop_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPe && !st.prog && !st.erase) |=> (!st.prog && !st.erase));
endmodule

// File: rtl/flash_ilk_ctrl.sv
module flash_ilk_ctrl
  import flash_ilk_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtRst,
  input  logic              standbyIn,
  input  logic              fwePin,
  input  logic              bootMode,
  input  logic              bootActive,
  input  logic              wdtEnabled,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  flashStateT        st,
  output strobeT            strb,
  output logic              pgmMode,
  output logic              eraseMode,
  output logic              irqMask,
  output logic              busRelMask,
  output logic              wdtWarn
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] EMU_SEL = ADDR_W'(EMU_ADDR);

  logic hitCtl, hitEmu, clearNow, peActive, anyArmed, qualOk;

  always_comb begin
    hitCtl   = (busAddr == CTL_SEL);
    hitEmu   = (busAddr == EMU_SEL);
    clearNow = wdtRst | standbyIn | ~fwePin | ~st.swWe;
    strb.wrCtl = busWe & hitCtl;
    strb.wrEmu = busWe & hitEmu;
    strb.rdEn  = busRe;
    strb.rdCtl = hitCtl;
    strb.rdEmu = hitEmu;
    strb.clrPe = clearNow;
    peActive = st.prog | st.erase;
    anyArmed = st.progSetup | st.eraseSetup | peActive;
    qualOk   = fwePin & st.swWe & ~st.emuSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmMode    <= 1'b0;
      eraseMode  <= 1'b0;
      irqMask    <= 1'b0;
      busRelMask <= 1'b0;
      wdtWarn    <= 1'b0;
    end else begin
      pgmMode    <= st.prog & qualOk;
      eraseMode  <= st.erase & qualOk;
      irqMask    <= peActive | (bootMode & bootActive);
      busRelMask <= peActive;
      wdtWarn    <= anyArmed & ~wdtEnabled;
    end
  end

  assert_irq_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    (st.prog || st.erase) |=> irqMask);
  assert_busrel_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.prog || st.erase) |=> busRelMask);
  assert_boot_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bootMode && bootActive) |=> irqMask);
  assert_wdt_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> (!st.prog && !st.erase));
  assert_standby_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    standbyIn |=> (!st.prog && !st.erase));
  assert_pin_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fwePin |=> (!st.prog && !st.erase));
  assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fwePin && !st.swWe) |=> (!st.prog && !st.erase));
  assert_emu_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.emuSel |=> (!pgmMode && !eraseMode));
  assert_set_guard_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.prog) |-> $past(fwePin && st.swWe && !wdtRst && !standbyIn));
endmodule

// File: rtl/flash_pe_interlock.sv
module flash_pe_interlock
  import flash_ilk_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtRst,
  input  logic              standbyIn,
  input  logic              fwePin,
  input  logic              bootMode,
  input  logic              bootActive,
  input  logic              wdtEnabled,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pgmMode,
  output logic              eraseMode,
  output logic              irqMask,
  output logic              busRelMask,
  output logic              wdtWarn
);
  strobeT     strb;
  flashStateT st;

  flash_ilk_ctrl #(.ADDR_W(ADDR_W)) ctrlU (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .standbyIn(standbyIn),
    .fwePin(fwePin), .bootMode(bootMode), .bootActive(bootActive),
    .wdtEnabled(wdtEnabled), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .st(st), .strb(strb), .pgmMode(pgmMode),
    .eraseMode(eraseMode), .irqMask(irqMask), .busRelMask(busRelMask),
    .wdtWarn(wdtWarn)
  );

  flash_ilk_datapath #(.DATA_W(DATA_W)) dpU (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(busWdata),
    .st(st), .rData(busRdata)
  );
endmodule

// File: tb/flash_pe_interlock_test.sv
`timescale 1ns/100ps
module flash_pe_interlock_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdtRst = 0, standbyIn = 0, fwePin = 0, bootMode = 0, bootActive = 0;
  logic wdtEnabled = 1, busWe = 0, busRe = 0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic pgmMode, eraseMode, irqMask, busRelMask, wdtWarn;
  int nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  flash_pe_interlock uut (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .standbyIn(standbyIn),
    .fwePin(fwePin), .bootMode(bootMode), .bootActive(bootActive),
    .wdtEnabled(wdtEnabled), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pgmMode(pgmMode), .eraseMode(eraseMode), .irqMask(irqMask),
    .busRelMask(busRelMask), .wdtWarn(wdtWarn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] emuList [4];
    emuList[0] = 8'h00; emuList[1] = 8'h05; emuList[2] = 8'h08; emuList[3] = 8'h0F;

    // R4: reset state
    #1;
    chk("R4 reset outputs", {pgmMode, eraseMode, irqMask, busRelMask, wdtWarn}, 0);
    chk("R4 reset rdata", busRdata, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R6 R7 R8 R9 R10 R11: exhaustive sweep
    for (int e = 0; e < 4; e++)
      for (int f = 0; f < 2; f++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 32; d++) begin
            logic p, er, emuSel, expPgm, expErs;
            logic [7:0] expCtl;
            fwePin = f[0]; wdtEnabled = w[0];
            busWrite(2'd1, emuList[e]);
            busWrite(2'd0, 8'h10);
            busWrite(2'd0, 8'(d));
            repeat (3) @(negedge clk);
            emuSel = emuList[e][3];
            p  = d[1] & f[0] & d[4];
            er = d[3] & f[0] & d[4];
            expPgm = p & ~emuSel;
            expErs = er & ~emuSel;
            expCtl = {3'b000, d[4], er, d[2], p, d[0]};
            chk(emuSel ? "R8 pgmMode blocked" : "R9 pgmMode", pgmMode, expPgm);
            chk(emuSel ? "R8 eraseMode blocked" : "R9 eraseMode", eraseMode, expErs);
            chk("R1 irqMask", irqMask, p | er);
            chk("R2 busRelMask", busRelMask, p | er);
            chk("R10 wdtWarn", wdtWarn, (d[0] | d[2] | p | er) & ~w[0]);
            busRead(2'd0, rd);
            chk(f[0] ? "R7 R11 ctl readback" : "R6 R11 ctl readback", rd, expCtl);
            busRead(2'd1, rd);
            chk("R11 emu readback", rd, emuList[e]);
          end

    // R11: unmapped addresses read 0; rdata holds without busRe
    busRead(2'd2, rd); chk("R11 addr2", rd, 0);
    busRead(2'd3, rd); chk("R11 addr3", rd, 0);
    busRead(2'd1, rd);
    repeat (2) @(negedge clk);
    chk("R11 rdata hold", busRdata, 8'h0F);
    busWrite(2'd1, 8'h00);

    // R12: write in the same cycle the pin drops is dropped, not set-then-cleared
    fwePin = 1'b1; wdtEnabled = 1'b1;
    busWrite(2'd0, 8'h10);
    fwePin = 1'b0;
    busWrite(2'd0, 8'h1B);
    busRead(2'd0, rd);
    chk("R12 pin-drop write dropped", rd, 8'h11);
    chk("R12 no mask glitch", irqMask, 0);
    fwePin = 1'b1;
    busWrite(2'd0, 8'h10);
    busWrite(2'd0, 8'h12);
    busRead(2'd0, rd);
    chk("R12 control write accepted", rd, 8'h12);
    // stored swWe=0 drops prog even when same write sets swWe
    busWrite(2'd0, 8'h00);
    busWrite(2'd0, 8'h1A);
    busRead(2'd0, rd);
    chk("R12 stale swWe drops", rd, 8'h10);
    // standby in write cycle
    standbyIn = 1'b1;
    busWrite(2'd0, 8'h1A);
    standbyIn = 1'b0;
    busRead(2'd0, rd);
    chk("R12 standby write dropped", rd, 8'h10);

    // R5: standby clears only program and erase
    busWrite(2'd0, 8'h1F);
    busRead(2'd0, rd); chk("R5 armed", rd, 8'h1F);
    standbyIn = 1'b1; @(negedge clk); standbyIn = 1'b0;
    busRead(2'd0, rd); chk("R5 standby clears", rd, 8'h15);

    // R4: watchdog reset clears only program and erase
    busWrite(2'd0, 8'h1F);
    wdtRst = 1'b1; @(negedge clk); wdtRst = 1'b0;
    busRead(2'd0, rd); chk("R4 wdt reset clears", rd, 8'h15);

    // R3: boot masking
    busWrite(2'd0, 8'h10);
    bootMode = 1'b1; bootActive = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 boot irqMask", irqMask, 1);
    chk("R3 R2 boot busRelMask", busRelMask, 0);
    bootMode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 bootActive alone", irqMask, 0);
    bootActive = 1'b0;

    // R4: asynchronous reset clears everything mid-cycle
    busWrite(2'd1, 8'h0D);
    busWrite(2'd0, 8'h1F);
    busRead(2'd0, rd);
    repeat (2) @(negedge clk);
    chk("R4 pre-reset mask", irqMask, 1);
    #1 rstN = 1'b0;
    #0.5;
    chk("R4 async outputs", {pgmMode, eraseMode, irqMask, busRelMask, wdtWarn}, 0);
    chk("R4 async rdata", busRdata, 0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    busRead(2'd0, rd); chk("R4 ctl after reset", rd, 0);
    busRead(2'd1, rd); chk("R4 emu after reset", rd, 0);

    summary();
    $finish;
  end
endmodule